// File: doc/BRIEF.md
# Port Termination Context Mapper

This block sits at the head of the ingress pipeline. Packet bytes arrive one per cycle. Each byte carries start and end marks and is tagged with the physical interface and channel it came in on. The mapper resolves attributes in two steps. First, the interface and channel pair selects a termination context and a reassembly context. Second, the termination context selects a source system port, an in-PP-port, and a flag saying whether packets on that context begin with an in-band control header.

For contexts with the flag set, the block parses the two-byte control header and removes it from the stream. If the header's override bit is set, its second byte replaces the configured in-PP-port. This lets an injecting host make a packet appear to arrive on a port of its choice. All attributes are captured when a packet starts and are held until it ends. Software loads both mapping tables through a simple write port. A write only affects packets that start after it.

Packets do not interleave on the input bus. A start mark always begins a new packet, even if the previous one has not ended.

Top module: `ptc_mapper`

## Requirements
- R1: After reset every output is 0 and every entry of both tables is 0, so an unconfigured source maps to context 0, reassembly context 0, system port 0, in-PP-port 0 and no control header.
- R2: On a context without a control header, each accepted byte appears on the output exactly one cycle later with unchanged data. The first byte carries out_sop and the byte marked in_eop carries out_eop.
- R3: The index {in_intf, in_chan} reads the first table. Its entry is written with cfg_tbl=0, cfg_addr = index, cfg_data[3:0] = context and cfg_data[15:8] = reassembly context. The context reads the second table. That entry is written with cfg_tbl=1, cfg_addr = context, cfg_data[14:0] = source system port, cfg_data[23:16] = in-PP-port and cfg_data[24] = header flag.
- R4: Different channels may map to one context, to separate contexts, or to separate contexts that share one reassembly context. The outputs follow each mapping.
- R5: On a context with the header flag set, the first two bytes of each packet are removed. The third byte is emitted one cycle after it is accepted and carries out_sop.
- R6: Header byte 0 bit 7 is the override flag and bits 6:0 are ignored. When the flag is 1, header byte 1 becomes out_pp. When it is 0, the configured in-PP-port is used. The source system port always comes from the table.
- R7: A packet on a header context that ends within its first two bytes produces no output.
- R8: out_ptc, out_reasm, out_ssp and out_pp stay constant on every byte of a packet, including across idle gaps between its bytes.
- R9: A table write does not change a packet already started. This includes a write in the same cycle as that packet's start byte. The next packet uses the new value.
- R10: Valid bytes received while no packet is open are dropped.
- R11: A start byte arriving inside an open packet abandons that packet and begins a new one with freshly looked-up attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_data | input | 8 | Input byte |
| in_intf | input | IF_W | Physical interface tag |
| in_chan | input | CH_W | Channel tag |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | 0: source table, 1: context table |
| cfg_addr | input | 8 | Table entry index |
| cfg_data | input | 32 | Entry contents |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First emitted byte of a packet |
| out_eop | output | 1 | Last emitted byte of a packet |
| out_data | output | 8 | Output byte |
| out_ptc | output | PTC_W | Termination context |
| out_reasm | output | 8 | Reassembly context |
| out_ssp | output | 15 | Source system port |
| out_pp | output | 8 | In-PP-port |

## Verification
Every emitted byte is due on the first clock edge after the input byte it came from. Removed header bytes and dropped stray bytes are never due at all. The bench drives one byte per falling edge. When it drives a byte, it computes that byte's expected output and attributes from its own copy of the tables and queues the result. At each later falling edge it compares any valid output against the head of that queue. Cases where no output is expected are closed by letting the pipeline idle for a few cycles, then confirming that the queue is empty and that no unexpected byte appeared.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int SSP_W   = 15;
    localparam int PP_W    = 8;
    localparam int RC_W    = 8;
    localparam int BYTE_W  = 8;
    localparam int CFG_AW  = 8;
    localparam int CFG_DW  = 32;

    localparam int RC_LSB     = 8;
    localparam int PP_LSB     = 16;
    localparam int HEN_BIT    = 24;
    localparam int OVR_BIT    = 7;

    typedef logic [SSP_W-1:0] ssp_t;
    typedef logic [PP_W-1:0]  pp_t;
    typedef logic [RC_W-1:0]  rc_t;

    typedef struct packed {
        logic hdr_en;
        pp_t  pp;
        ssp_t ssp;
    } ctx_entry_t;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_HDR  = 2'd1,
        PS_BODY = 2'd2
    } pstate_t;

    function automatic ctx_entry_t cfg_to_ctx(input logic [CFG_DW-1:0] d);
        ctx_entry_t e;
        e.hdr_en = d[HEN_BIT];
        e.pp     = d[PP_LSB +: PP_W];
        e.ssp    = d[SSP_W-1:0];
        return e;
    endfunction

endpackage

// File: rtl/ptc_cfg_table.sv
module ptc_cfg_table #(
    parameter int AW = 4,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ptc_hdr_parser.sv
module ptc_hdr_parser
    import ptc_pkg::*;
#(
    parameter int PTC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BYTE_W-1:0] in_data,
    input  logic [PTC_W-1:0]  lk_ptc,
    input  rc_t               lk_reasm,
    input  ctx_entry_t        lk_ent,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [BYTE_W-1:0] out_data,
    output logic [PTC_W-1:0]  out_ptc,
    output rc_t               out_reasm,
    output ssp_t              out_ssp,
    output pp_t               out_pp
);
    pstate_t state;
    logic    pend_sop;
    logic    ovr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PS_IDLE;
            pend_sop  <= 1'b0;
            ovr       <= 1'b0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_data  <= '0;
            out_ptc   <= '0;
            out_reasm <= '0;
            out_ssp   <= '0;
            out_pp    <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            if (in_valid) begin
                if (in_sop) begin
                    out_ptc   <= lk_ptc;
                    out_reasm <= lk_reasm;
                    out_ssp   <= lk_ent.ssp;
                    out_pp    <= lk_ent.pp;
                    pend_sop  <= 1'b0;
                    if (lk_ent.hdr_en) begin
                        ovr   <= in_data[OVR_BIT];
                        state <= in_eop ? PS_IDLE : PS_HDR;
                    end else begin
                        out_valid <= 1'b1;
                        out_sop   <= 1'b1;
                        out_eop   <= in_eop;
                        out_data  <= in_data;
                        state     <= in_eop ? PS_IDLE : PS_BODY;
                    end
                end else begin
                    case (state)
                        PS_HDR: begin
                            if (ovr) out_pp <= in_data;
                            pend_sop <= !in_eop;
                            state    <= in_eop ? PS_IDLE : PS_BODY;
                        end
                        PS_BODY: begin
                            out_valid <= 1'b1;
                            out_sop   <= pend_sop;
                            out_eop   <= in_eop;
                            out_data  <= in_data;
                            pend_sop  <= 1'b0;
                            if (in_eop) state <= PS_IDLE;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/ptc_mapper.sv
module ptc_mapper
    import ptc_pkg::*;
#(
    parameter int IF_W  = 2,
    parameter int CH_W  = 2,
    parameter int PTC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [7:0]        in_data,
    input  logic [IF_W-1:0]   in_intf,
    input  logic [CH_W-1:0]   in_chan,
    input  logic              cfg_we,
    input  logic              cfg_tbl,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [7:0]        out_data,
    output logic [PTC_W-1:0]  out_ptc,
    output logic [7:0]        out_reasm,
    output logic [14:0]       out_ssp,
    output logic [7:0]        out_pp
);
    localparam int SRC_W = IF_W + CH_W;
    localparam int L1_W  = PTC_W + RC_W;
    localparam int L2_W  = $bits(ctx_entry_t);

    logic [SRC_W-1:0] src_idx;
    logic [L1_W-1:0]  l1_wdata, l1_rdata;
    logic [L2_W-1:0]  l2_wdata, l2_rdata;
    logic [PTC_W-1:0] lk_ptc;
    rc_t              lk_reasm;
    ctx_entry_t       lk_ent;
    logic             unused_cfg_bits;

    assign src_idx  = {in_intf, in_chan};
    assign l1_wdata = {cfg_data[RC_LSB +: RC_W], cfg_data[PTC_W-1:0]};
    assign l2_wdata = cfg_to_ctx(cfg_data);
    assign unused_cfg_bits = ^{cfg_data[CFG_DW-1:HEN_BIT+1], cfg_addr};

    ptc_cfg_table #(.AW(SRC_W), .W(L1_W)) src_tbl_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we && !cfg_tbl),
        .waddr (cfg_addr[SRC_W-1:0]),
        .wdata (l1_wdata),
        .raddr (src_idx),
        .rdata (l1_rdata)
    );

    assign lk_ptc   = l1_rdata[PTC_W-1:0];
    assign lk_reasm = l1_rdata[L1_W-1:PTC_W];

    ptc_cfg_table #(.AW(PTC_W), .W(L2_W)) ctx_tbl_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we && cfg_tbl),
        .waddr (cfg_addr[PTC_W-1:0]),
        .wdata (l2_wdata),
        .raddr (lk_ptc),
        .rdata (l2_rdata)
    );

    assign lk_ent = ctx_entry_t'(l2_rdata);

    ptc_hdr_parser #(.PTC_W(PTC_W)) parser_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .lk_ptc    (lk_ptc),
        .lk_reasm  (lk_reasm),
        .lk_ent    (lk_ent),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_data  (out_data),
        .out_ptc   (out_ptc),
        .out_reasm (out_reasm),
        .out_ssp   (out_ssp),
        .out_pp    (out_pp)
    );
endmodule

// File: rtl/ptc_mapper_chk.sv
module ptc_mapper_chk #(
    parameter int PTC_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_sop,
    input logic             in_eop,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic [PTC_W-1:0] out_ptc,
    input logic [7:0]       out_reasm,
    input logic [14:0]      out_ssp,
    input logic [7:0]       out_pp
);
    logic in_open;
    logic out_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_open  <= 1'b0;
            out_open <= 1'b0;
        end else begin
            if (in_valid) in_open <= !in_eop;
            if (out_valid) out_open <= !out_eop;
        end
    end

    assert_out_follows_in_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_marks_need_valid_R2: assert property (@(posedge clk) disable iff (rst)
        (out_sop || out_eop) |-> out_valid);

    assert_first_byte_sop_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_open) |-> out_sop);

    assert_attr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sop) |-> $stable({out_ptc, out_reasm, out_ssp, out_pp}));

    assert_stray_dropped_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_sop || in_open));
endmodule

bind ptc_mapper ptc_mapper_chk #(.PTC_W(PTC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_ptc   (out_ptc),
    .out_reasm (out_reasm),
    .out_ssp   (out_ssp),
    .out_pp    (out_pp)
);

// File: tb/ptc_mapper_tb_top.sv
`timescale 1ns/1ps
module ptc_mapper_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sop, in_eop;
    logic [7:0]  in_data;
    logic [1:0]  in_intf, in_chan;
    logic        cfg_we, cfg_tbl;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_data;
    logic        out_valid, out_sop, out_eop;
    logic [7:0]  out_data;
    logic [3:0]  out_ptc;
    logic [7:0]  out_reasm;
    logic [14:0] out_ssp;
    logic [7:0]  out_pp;

    always #4 clk = ~clk;

    ptc_mapper dut_i (.*);

    typedef struct packed {
        logic        sop;
        logic        eop;
        logic [7:0]  d;
        logic [3:0]  ptc;
        logic [7:0]  rc;
        logic [14:0] ssp;
        logic [7:0]  pp;
    } exp_t;

    logic [3:0]  m_ptc [16];
    logic [7:0]  m_rc  [16];
    logic [14:0] m_ssp [16];
    logic [7:0]  m_pp  [16];
    logic        m_hen [16];

    exp_t  q[$];
    string tq[$];
    logic [7:0] pkt [64];
    int n_tests = 0, n_fail = 0, n_unexp = 0, unexp_mark = 0;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic apply_cfg(input logic tbl, input logic [7:0] a, input logic [31:0] d);
        if (!tbl) begin
            m_ptc[a[3:0]] = d[3:0];
            m_rc[a[3:0]]  = d[15:8];
        end else begin
            m_ssp[a[3:0]] = d[14:0];
            m_pp[a[3:0]]  = d[23:16];
            m_hen[a[3:0]] = d[24];
        end
    endtask

    task automatic cfg(input logic tbl, input logic [7:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_tbl = tbl; cfg_addr = a; cfg_data = d;
        tick();
        cfg_we = 1'b0;
        apply_cfg(tbl, a, d);
    endtask

    function automatic logic [31:0] l1_word(input int ptc, input int rc);
        return (32'(rc) << 8) | 32'(ptc);
    endfunction

    function automatic logic [31:0] l2_word(input int ssp, input int pp, input bit hen);
        return (32'(hen) << 24) | (32'(pp) << 16) | 32'(ssp);
    endfunction

    task automatic send_pkt(input int intf, input int chan, input int len, input bit gaps,
                            input bit no_eop, input int cw_at, input logic cw_tbl,
                            input logic [7:0] cw_addr, input logic [31:0] cw_data,
                            input string tag);
        logic [3:0]  p;
        logic [7:0]  rc, pp;
        logic [14:0] ssp;
        logic        hen;
        exp_t        e;
        p   = m_ptc[{intf[1:0], chan[1:0]}];
        rc  = m_rc[{intf[1:0], chan[1:0]}];
        ssp = m_ssp[p];
        pp  = m_pp[p];
        hen = m_hen[p];
        if (hen && len >= 2 && pkt[0][7]) pp = pkt[1];
        for (int i = 0; i < len; i++) begin
            if (gaps && i > 0 && ($urandom % 3) == 0) begin
                in_valid = 1'b0;
                repeat (1 + $urandom % 2) tick();
            end
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == len - 1) && !no_eop;
            in_data  = pkt[i];
            in_intf  = intf[1:0];
            in_chan  = chan[1:0];
            if (cw_at == i) begin
                cfg_we = 1'b1; cfg_tbl = cw_tbl; cfg_addr = cw_addr; cfg_data = cw_data;
            end
            if (!hen || i >= 2) begin
                e.sop = (i == (hen ? 2 : 0));
                e.eop = in_eop;
                e.d   = pkt[i];
                e.ptc = p; e.rc = rc; e.ssp = ssp; e.pp = pp;
                q.push_back(e);
                tq.push_back(tag);
            end
            tick();
            if (cw_at == i) begin
                cfg_we = 1'b0;
                apply_cfg(cw_tbl, cw_addr, cw_data);
            end
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic fill_pkt(input int len);
        for (int i = 0; i < len; i++) pkt[i] = 8'($urandom);
    endtask

    task automatic drained(input string tag);
        repeat (3) tick();
        n_tests++;
        if (q.size() != 0 || n_unexp != unexp_mark) begin
            n_fail++;
            $display("FAIL %s: pending=%0d unexpected=%0d, expected pending=0 unexpected=0",
                     tag, q.size(), n_unexp - unexp_mark);
            q.delete(); tq.delete();
        end
        unexp_mark = n_unexp;
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_tests++;
            if (q.size() == 0) begin
                n_unexp++;
                n_fail++;
                $display("FAIL unexpected output byte: actual data=%02h, expected none", out_data);
            end else begin
                exp_t  e;
                string t;
                e = q.pop_front();
                t = tq.pop_front();
                if ({out_sop, out_eop, out_data, out_ptc, out_reasm, out_ssp, out_pp} !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual sop=%0b eop=%0b d=%02h ptc=%0d rc=%0d ssp=%0d pp=%02h, expected sop=%0b eop=%0b d=%02h ptc=%0d rc=%0d ssp=%0d pp=%02h",
                             t, out_sop, out_eop, out_data, out_ptc, out_reasm, out_ssp, out_pp,
                             e.sop, e.eop, e.d, e.ptc, e.rc, e.ssp, e.pp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual run still active, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c7a));
        for (int i = 0; i < 16; i++) begin
            m_ptc[i] = '0; m_rc[i] = '0; m_ssp[i] = '0; m_pp[i] = '0; m_hen[i] = 1'b0;
        end
        rst = 1'b1;
        in_valid = 0; in_sop = 0; in_eop = 0; in_data = 0; in_intf = 0; in_chan = 0;
        cfg_we = 0; cfg_tbl = 0; cfg_addr = 0; cfg_data = 0;
        repeat (3) tick();
        n_tests++;
        if ({out_valid, out_sop, out_eop, out_data, out_ptc, out_reasm, out_ssp, out_pp} !== '0) begin
            n_fail++;
            $display("FAIL R1 reset outputs: actual %h, expected 0",
                     {out_valid, out_sop, out_eop, out_data, out_ptc, out_reasm, out_ssp, out_pp});
        end
        rst = 1'b0;
        tick();

        // R1: unconfigured tables resolve to zero attributes
        fill_pkt(4);
        send_pkt(3, 2, 4, 0, 0, -1, 0, 0, 0, "R1");
        drained("R1");

        // R3 and R4: interface 1 unchannelized, 2 interleaved, 3 shared reassembly
        for (int c = 0; c < 4; c++) begin
            cfg(0, 8'(4 + c),  l1_word(1, 10));
            cfg(0, 8'(8 + c),  l1_word(4 + c, 20 + c));
            cfg(0, 8'(12 + c), l1_word(8 + c, 30));
        end
        for (int p = 0; p < 16; p++)
            cfg(1, 8'(p), l2_word(100 * p + 7, p + 8'h40, (p == 5 || p == 9)));
        for (int c = 0; c < 4; c++) begin
            fill_pkt(3);
            send_pkt(1, c, 3, 0, 0, -1, 0, 0, 0, "R3");
            fill_pkt(3);
            send_pkt(2, c == 1 ? 0 : c, 3, 0, 0, -1, 0, 0, 0, "R4");
        end
        fill_pkt(3);
        send_pkt(3, 0, 3, 0, 0, -1, 0, 0, 0, "R4");
        fill_pkt(5);
        send_pkt(3, 2, 5, 0, 0, -1, 0, 0, 0, "R2");
        drained("R3");

        // R5 and R6: header context 5 (intf 2 chan 1) and 9 (intf 3 chan 1)
        fill_pkt(6); pkt[0] = 8'h80; pkt[1] = 8'hA5;
        send_pkt(2, 1, 6, 0, 0, -1, 0, 0, 0, "R6");
        fill_pkt(4); pkt[0] = 8'h7F; pkt[1] = 8'h11;
        send_pkt(3, 1, 4, 0, 0, -1, 0, 0, 0, "R6");
        fill_pkt(3); pkt[0] = 8'hFF;
        send_pkt(2, 1, 3, 0, 0, -1, 0, 0, 0, "R5");
        drained("R5");

        // R7: header packets ending within the header
        fill_pkt(1); pkt[0] = 8'h80;
        send_pkt(2, 1, 1, 0, 0, -1, 0, 0, 0, "R7");
        fill_pkt(2); pkt[0] = 8'h80;
        send_pkt(3, 1, 2, 0, 0, -1, 0, 0, 0, "R7");
        drained("R7");

        // R10: stray valid bytes with no open packet
        for (int i = 0; i < 4; i++) begin
            in_valid = 1; in_sop = 0; in_eop = (i == 2); in_data = 8'(i); in_intf = 1; in_chan = 0;
            tick();
        end
        in_valid = 0; in_eop = 0;
        drained("R10");

        // R9: writes during a packet and in the sop cycle
        fill_pkt(5);
        send_pkt(1, 0, 5, 0, 0, 2, 1, 8'd1, l2_word(12345, 8'h99, 0), "R9");
        fill_pkt(3);
        send_pkt(1, 3, 3, 0, 0, 0, 0, 8'd7, l1_word(2, 77), "R9");
        fill_pkt(3);
        send_pkt(1, 3, 3, 0, 0, -1, 0, 0, 0, "R9");
        fill_pkt(3);
        send_pkt(1, 1, 3, 0, 0, 0, 1, 8'd1, l2_word(321, 8'h22, 0), "R9");
        fill_pkt(2);
        send_pkt(1, 1, 2, 0, 0, -1, 0, 0, 0, "R9");
        drained("R9");

        // R11: start mark inside an open packet
        fill_pkt(3);
        send_pkt(2, 0, 3, 0, 1, -1, 0, 0, 0, "R11");
        fill_pkt(4);
        send_pkt(2, 2, 4, 0, 0, -1, 0, 0, 0, "R11");
        fill_pkt(2); pkt[0] = 8'h80;
        send_pkt(2, 1, 2, 0, 1, -1, 0, 0, 0, "R11");
        fill_pkt(3);
        send_pkt(2, 3, 3, 0, 0, -1, 0, 0, 0, "R11");
        drained("R11");

        // R8: random packets with idle gaps and occasional table writes
        for (int n = 0; n < 60; n++) begin
            int len;
            len = 1 + int'($urandom % 12);
            fill_pkt(len);
            if (($urandom % 8) == 0)
                cfg(1, 8'($urandom % 16),
                    l2_word(int'($urandom % 32768), int'($urandom % 256), ($urandom % 2) == 1));
            send_pkt(int'($urandom % 4), int'($urandom % 4), len, 1, 0,
                     (($urandom % 4) == 0) ? int'($urandom % len) : -1,
                     1'($urandom), 8'($urandom % 16), 32'($urandom), "R8");
        end
        drained("R8");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule